// File: doc/BRIEF.md
# Nested Priority Interrupt Sequencer

This block watches a set of interrupt request lines and runs the entry and exit sequence that a small processor core follows to service them. Each line has a pending flag, an enable flag and a priority level. The block chooses the best request that is both enabled and pending. It starts service only when that request outranks the level the core is running at. Before the handler starts, the block saves the core's context over a word-wide memory port with a valid/ready handshake. It then reads the handler address from a vector table and hands that address to the core.

When a handler signals that it is done, the block restores the context of the code it interrupted, or of the background thread. Two shortcuts cut the overhead. If an eligible request is already waiting at handler exit, the restore and the next save are both skipped and the block goes straight to the next vector read. If a more urgent request turns up while context is still being saved, the save runs to completion only once, and the vector read is for the urgent request. The request that started the save stays pending.

An internal stack of active priorities tracks nesting. Status ports report the current handler number, the nesting depth, and how the most recent entry was reached. This lets a bench confirm each path.

Top module: `nest_irq_seq`

## Requirements
- R1: After reset, every pending flag, enable flag and priority field is zero, the nesting depth is zero and the memory port is idle. A rising edge on a request line sets that line's pending flag. The flag stays set until the one-cycle accept strobe for that line clears it. A rising edge in the same cycle as the clear wins.
- R2: A disabled line can still become pending, but it is never accepted. Once it is enabled, its held pending flag can be accepted.
- R3: Among lines that are pending and enabled, the best one has the numerically lowest priority value. On equal priority, the lowest line number wins.
- R4: A request preempts only when its priority value is strictly below the running level. The running level is the priority on top of the active stack, or a thread level above all priorities when the stack is empty. An equal-priority request waits.
- R5: A fresh entry runs CTX_WORDS stacking transfers (op 0, address = word index counting up from 0). Then comes a one-cycle accept strobe carrying the line number, then one vector read (op 2, address = VEC_BASE + 4 × line number). The cycle after that read completes, handler_start pulses and handler_pc holds the read data. entry_kind reads 0 after a fresh entry.
- R6: Each transfer holds mem_valid, mem_op and mem_addr steady until a cycle with mem_ready high completes it, however many wait cycles that takes.
- R7: When handler_done exits a handler and no request outranks the level being returned to, the block pops the stack. It runs CTX_WORDS unstacking transfers (op 1, address = word index) and then pulses resume for one cycle.
- R8: When a request outranks the level being returned to at handler exit, no unstacking or stacking transfer occurs. The accept strobe follows in the next cycle, the depth is unchanged after the swap, and entry_kind reads 1.
- R9: If a request with a strictly lower priority value than the current target becomes pending during stacking, it becomes the target. Stacking still totals CTX_WORDS transfers, the new target is accepted, the earlier target stays pending, and entry_kind reads 2.
- R10: A new rising edge on a line while its handler runs sets that line's pending flag again.
- R11: nest_depth counts the handlers on the active stack and changes by at most one per cycle. active_id shows the line on top of the stack.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_LINES | Request lines, rising edge sets pending |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | LINE_W | Line addressed by a configuration write |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | PRIO_W | Priority value to write (lower is more urgent) |
| handler_done | input | 1 | Running handler has finished |
| mem_ready | input | 1 | Memory completes the current transfer |
| mem_rdata | input | ADDR_W | Read data for vector reads |
| mem_valid | output | 1 | Transfer request |
| mem_op | output | 2 | 0 stack word, 1 unstack word, 2 vector read |
| mem_addr | output | ADDR_W | Word index or vector address |
| accept_strobe | output | 1 | One-cycle accept of a line |
| accept_id | output | LINE_W | Line being accepted |
| handler_start | output | 1 | One-cycle start of handler |
| handler_pc | output | ADDR_W | Handler start address |
| resume | output | 1 | One-cycle return to interrupted code |
| active_id | output | LINE_W | Line on top of the active stack |
| nest_depth | output | DEPTH_W | Number of nested handlers |
| entry_kind | output | 2 | Last entry: 0 fresh, 1 chained, 2 late arrival |
| pending | output | N_LINES | Pending flags |

## Verification
The bench uses the defaults: eight lines, three-bit priorities, eight context words and an eight-deep stack. This gives eight distinct levels, so the full nesting depth and every priority tie can be reached. It switches between an always-ready memory, a memory that stalls half the time and one that stalls most of the time. The slow memory keeps stacking open long enough to inject a late, more urgent request mid-save. Directed sequences cover ties, equal-priority waiting, chaining and re-pending. A random phase then gives all lines distinct levels to drive deep nesting.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SAVE = 3'd1,
    ST_ACC  = 3'd2,
    ST_VEC  = 3'd3,
    ST_REST = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    ENTRY_FRESH = 2'd0,
    ENTRY_CHAIN = 2'd1,
    ENTRY_LATE  = 2'd2
  } entry_kind_e;

  typedef enum logic [1:0] {
    OP_STACK   = 2'd0,
    OP_UNSTACK = 2'd1,
    OP_VECTOR  = 2'd2
  } mem_op_e;

endpackage

// File: rtl/nirq_pend.sv
module nirq_pend #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LINES-1:0]          irq_req,
  input  logic                        cfg_we,
  input  logic [LINE_W-1:0]           cfg_line,
  input  logic                        cfg_en,
  input  logic [PRIO_W-1:0]           cfg_prio,
  input  logic [N_LINES-1:0]          clr_vec,
  output logic [N_LINES-1:0]          pending,
  output logic [N_LINES-1:0]          enabled,
  output logic [N_LINES*PRIO_W-1:0]   prio_flat,
  output logic [N_LINES-1:0]          set_vec
);

  logic [N_LINES-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= irq_req;
  end

  assign set_vec = irq_req & ~req_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic              pend_r;
    logic              en_r;
    logic [PRIO_W-1:0] prio_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= 1'b0;
        en_r   <= 1'b0;
        prio_r <= '0;
      end else begin
        pend_r <= (pend_r & ~clr_vec[g]) | set_vec[g];
        if (cfg_we && cfg_line == LINE_W'(g)) begin
          en_r   <= cfg_en;
          prio_r <= cfg_prio;
        end
      end
    end

    assign pending[g]                     = pend_r;
    assign enabled[g]                     = en_r;
    assign prio_flat[g*PRIO_W +: PRIO_W]  = prio_r;
  end

endmodule

// File: rtl/nirq_arb.sv
module nirq_arb #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        pending,
  input  logic [N_LINES-1:0]        enabled,
  input  logic [N_LINES*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [LINE_W-1:0]         best_id,
  output logic [PRIO_W-1:0]         best_prio
);

  function automatic logic [PRIO_W-1:0] prio_of(input logic [N_LINES*PRIO_W-1:0] f,
                                                input int i);
    return f[i*PRIO_W +: PRIO_W];
  endfunction

  // strict compare keeps the lower line number on a tie
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (pending[i] && enabled[i] && (!found || prio_of(prio_flat, i) < best_prio)) begin
        found     = 1'b1;
        best_id   = LINE_W'(i);
        best_prio = prio_of(prio_flat, i);
      end
    end
  end

endmodule

// File: rtl/nirq_stack.sv
module nirq_stack #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 3,
  parameter int PRIO_W = 3,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [ID_W-1:0]    push_id,
  input  logic [PRIO_W-1:0]  push_prio,
  output logic [DEPTH_W-1:0] depth,
  output logic               top_valid,
  output logic [ID_W-1:0]    top_id,
  output logic [PRIO_W-1:0]  top_prio,
  output logic               under_valid,
  output logic [PRIO_W-1:0]  under_prio
);

  logic [ID_W-1:0]   slot_id   [DEPTH];
  logic [PRIO_W-1:0] slot_prio [DEPTH];
  logic [SLOT_W-1:0] top_slot, under_slot, next_slot;

  assign top_slot    = SLOT_W'(depth - DEPTH_W'(1));
  assign under_slot  = SLOT_W'(depth - DEPTH_W'(2));
  assign next_slot   = SLOT_W'(depth);
  assign top_valid   = (depth != '0);
  assign under_valid = (depth > DEPTH_W'(1));
  assign top_id      = top_valid   ? slot_id[top_slot]     : '0;
  assign top_prio    = top_valid   ? slot_prio[top_slot]   : '0;
  assign under_prio  = under_valid ? slot_prio[under_slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_id[i]   <= '0;
        slot_prio[i] <= '0;
      end
    end else if (pop && top_valid) begin
      depth <= depth - DEPTH_W'(1);
    end else if (push && depth != DEPTH_W'(DEPTH)) begin
      slot_id[next_slot]   <= push_id;
      slot_prio[next_slot] <= push_prio;
      depth                <= depth + DEPTH_W'(1);
    end
  end

endmodule

// File: rtl/nest_irq_seq.sv
module nest_irq_seq
  import nirq_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int PRIO_W      = 3,
  parameter int CTX_WORDS   = 8,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = ADDR_W'('h100),
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  irq_req,
  input  logic                cfg_we,
  input  logic [LINE_W-1:0]   cfg_line,
  input  logic                cfg_en,
  input  logic [PRIO_W-1:0]   cfg_prio,
  input  logic                handler_done,
  input  logic                mem_ready,
  input  logic [ADDR_W-1:0]   mem_rdata,
  output logic                mem_valid,
  output logic [1:0]          mem_op,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                accept_strobe,
  output logic [LINE_W-1:0]   accept_id,
  output logic                handler_start,
  output logic [ADDR_W-1:0]   handler_pc,
  output logic                resume,
  output logic [LINE_W-1:0]   active_id,
  output logic [DEPTH_W-1:0]  nest_depth,
  output logic [1:0]          entry_kind,
  output logic [N_LINES-1:0]  pending
);

  localparam int CNT_W = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1;
  localparam logic [PRIO_W:0] THREAD_LVL = {1'b1, {PRIO_W{1'b0}}};

  function automatic logic [ADDR_W-1:0] vec_addr(input logic [LINE_W-1:0] id);
    return VEC_BASE + (ADDR_W'(id) << 2);
  endfunction

  function automatic logic [PRIO_W:0] level_of(input logic v, input logic [PRIO_W-1:0] p);
    return v ? {1'b0, p} : THREAD_LVL;
  endfunction

  seq_state_e          state;
  entry_kind_e         kind, last_kind;
  logic [CNT_W-1:0]    cnt;
  logic [LINE_W-1:0]   tgt_id;
  logic [PRIO_W-1:0]   tgt_prio;
  logic                hs_q, res_q;
  logic [ADDR_W-1:0]   pc_q;

  logic [N_LINES-1:0]        enabled, pend_set, pend_clr;
  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic                      found;
  logic [LINE_W-1:0]         best_id;
  logic [PRIO_W-1:0]         best_prio;
  logic                      top_valid, under_valid;
  logic [PRIO_W-1:0]         top_prio, under_prio;

  // named events
  logic xfer, last_word, do_push, do_pop, can_preempt, can_chain, late_take;

  assign mem_valid   = (state == ST_SAVE) || (state == ST_VEC) || (state == ST_REST);
  assign xfer        = mem_valid && mem_ready;
  assign last_word   = (cnt == CNT_W'(CTX_WORDS - 1));
  assign do_push     = (state == ST_ACC);
  assign do_pop      = (state == ST_RUN) && handler_done && top_valid;
  assign can_preempt = found && ({1'b0, best_prio} < level_of(top_valid, top_prio));
  assign can_chain   = found && ({1'b0, best_prio} < level_of(under_valid, under_prio));
  assign late_take   = (state == ST_SAVE) && found && (best_prio < tgt_prio);
  assign pend_clr    = do_push ? (N_LINES'(1) << tgt_id) : '0;

  nirq_pend #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
    .clr_vec(pend_clr), .pending(pending), .enabled(enabled),
    .prio_flat(prio_flat), .set_vec(pend_set)
  );

  nirq_arb #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
    .pending(pending), .enabled(enabled), .prio_flat(prio_flat),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  nirq_stack #(.DEPTH(STACK_DEPTH), .ID_W(LINE_W), .PRIO_W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .push_id(tgt_id), .push_prio(tgt_prio), .depth(nest_depth),
    .top_valid(top_valid), .top_id(active_id), .top_prio(top_prio),
    .under_valid(under_valid), .under_prio(under_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      kind      <= ENTRY_FRESH;
      last_kind <= ENTRY_FRESH;
      cnt       <= '0;
      tgt_id    <= '0;
      tgt_prio  <= '0;
      hs_q      <= 1'b0;
      res_q     <= 1'b0;
      pc_q      <= '0;
    end else begin
      hs_q  <= 1'b0;
      res_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (do_pop) begin
            cnt <= '0;
            if (can_chain) begin
              tgt_id   <= best_id;
              tgt_prio <= best_prio;
              kind     <= ENTRY_CHAIN;
              state    <= ST_ACC;
            end else begin
              state <= ST_REST;
            end
          end else if (can_preempt) begin
            tgt_id   <= best_id;
            tgt_prio <= best_prio;
            kind     <= ENTRY_FRESH;
            cnt      <= '0;
            state    <= ST_SAVE;
          end
        end
        ST_SAVE: begin
          if (late_take) begin
            tgt_id   <= best_id;
            tgt_prio <= best_prio;
            kind     <= ENTRY_LATE;
          end
          if (xfer) begin
            if (last_word) state <= ST_ACC;
            else           cnt   <= cnt + CNT_W'(1);
          end
        end
        ST_ACC: begin
          last_kind <= kind;
          state     <= ST_VEC;
        end
        ST_VEC: begin
          if (xfer) begin
            pc_q  <= mem_rdata;
            hs_q  <= 1'b1;
            state <= ST_RUN;
          end
        end
        ST_REST: begin
          if (xfer) begin
            if (last_word) begin
              res_q <= 1'b1;
              state <= ST_RUN;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_VEC:  mem_op = OP_VECTOR;
      ST_REST: mem_op = OP_UNSTACK;
      default: mem_op = OP_STACK;
    endcase
  end

  assign mem_addr      = (state == ST_VEC) ? vec_addr(tgt_id) : ADDR_W'(cnt);
  assign accept_strobe = do_push;
  assign accept_id     = tgt_id;
  assign handler_start = hs_q;
  assign handler_pc    = pc_q;
  assign resume        = res_q;
  assign entry_kind    = last_kind;

endmodule

// File: rtl/nest_irq_seq_chk.sv
module nest_irq_seq_chk #(
  parameter int N_LINES     = 8,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 32,
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [1:0]         mem_op,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               accept_strobe,
  input logic [LINE_W-1:0]  accept_id,
  input logic [N_LINES-1:0] pending,
  input logic [N_LINES-1:0] pend_set,
  input logic               handler_start,
  input logic               resume,
  input logic [DEPTH_W-1:0] nest_depth
);

  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_op));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    accept_strobe |=> !accept_strobe);

  a_r5_vector_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept_strobe |=> mem_valid && mem_op == 2'd2);

  a_r5_start_after_vector: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |-> $past(mem_valid) && $past(mem_ready) && $past(mem_op) == 2'd2);

  a_r1_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept_strobe && !pend_set[accept_id] |=> !pending[$past(accept_id)]);

  a_r7_resume_after_unstack: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(mem_valid) && $past(mem_ready) && $past(mem_op) == 2'd1);

  a_r11_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_depth - $past(nest_depth)) inside {DEPTH_W'(0), DEPTH_W'(1), {DEPTH_W{1'b1}}});

  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DEPTH_W'(STACK_DEPTH));

endmodule

bind nest_irq_seq nest_irq_seq_chk #(
  .N_LINES(N_LINES), .STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_op(mem_op), .mem_addr(mem_addr), .accept_strobe(accept_strobe),
  .accept_id(accept_id), .pending(pending), .pend_set(pend_set),
  .handler_start(handler_start), .resume(resume), .nest_depth(nest_depth)
);

// File: tb/nest_irq_seq_bench.sv
`timescale 1ns/1ps
module nest_irq_seq_bench;

  localparam int N = 8;
  localparam int CTXW = 8;
  localparam logic [31:0] VBASE = 32'h0000_0100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_line = '0;
  logic        cfg_en = 1'b0;
  logic [2:0]  cfg_prio = '0;
  logic        handler_done = 1'b0;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_rdata;
  logic        mem_valid, accept_strobe, handler_start, resume;
  logic [1:0]  mem_op, entry_kind;
  logic [31:0] mem_addr, handler_pc;
  logic [2:0]  accept_id, active_id;
  logic [3:0]  nest_depth;
  logic [N-1:0] pending;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[27:0], 4'h0} ^ 32'h8000_0001;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  nest_irq_seq u_nest_irq_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_en(cfg_en), .cfg_prio(cfg_prio), .handler_done(handler_done),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .mem_op(mem_op), .mem_addr(mem_addr), .accept_strobe(accept_strobe),
    .accept_id(accept_id), .handler_start(handler_start), .handler_pc(handler_pc),
    .resume(resume), .active_id(active_id), .nest_depth(nest_depth),
    .entry_kind(entry_kind), .pending(pending)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int rdy_mode = 0;
  int dut_saves = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state;            // 0 run, 1 save, 2 accept, 3 vector, 4 restore
  int m_cnt, m_tgt, m_tprio, m_kind, m_ekind;
  bit m_hs, m_res;
  logic [31:0] m_pc;
  logic [N-1:0] m_pend, m_en, m_irq_q;
  int m_prio [N];
  int stk_id [$];
  int stk_pr [$];

  function automatic int m_best();
    for (int p = 0; p < 8; p++)
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_en[i] && m_prio[i] == p) return i;
    return -1;
  endfunction

  function automatic int m_level();
    if (stk_pr.size() == 0) return 8;
    return stk_pr[stk_pr.size()-1];
  endfunction

  always @(posedge clk) begin
    int b, bp, st, lvl;
    bit xfer;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_tgt = 0; m_tprio = 0; m_kind = 0; m_ekind = 0;
      m_hs = 0; m_res = 0; m_pc = '0; m_pend = '0; m_en = '0; m_irq_q = '0;
      for (int i = 0; i < N; i++) m_prio[i] = 0;
      stk_id.delete(); stk_pr.delete();
    end else begin
      b  = m_best();
      bp = (b >= 0) ? m_prio[b] : 99;
      st = m_state;
      xfer = (st == 1 || st == 3 || st == 4) && mem_ready;
      m_hs = 0; m_res = 0;
      case (st)
        0: begin
          if (handler_done && stk_id.size() > 0) begin
            void'(stk_id.pop_back()); void'(stk_pr.pop_back());
            lvl = m_level();
            m_cnt = 0;
            if (b >= 0 && bp < lvl) begin
              m_tgt = b; m_tprio = bp; m_kind = 1; m_state = 2;
            end else m_state = 4;
          end else begin
            lvl = m_level();
            if (b >= 0 && bp < lvl) begin
              m_tgt = b; m_tprio = bp; m_kind = 0; m_cnt = 0; m_state = 1;
            end
          end
        end
        1: begin
          if (b >= 0 && bp < m_tprio) begin m_tgt = b; m_tprio = bp; m_kind = 2; end
          if (xfer) begin
            if (m_cnt == CTXW-1) m_state = 2; else m_cnt++;
          end
        end
        2: begin
          stk_id.push_back(m_tgt); stk_pr.push_back(m_tprio);
          m_ekind = m_kind; m_state = 3;
        end
        3: if (xfer) begin
          m_pc = mem_fn(VBASE + 32'(m_tgt) * 4); m_hs = 1; m_state = 0;
        end
        4: if (xfer) begin
          if (m_cnt == CTXW-1) begin m_res = 1; m_state = 0; end else m_cnt++;
        end
        default: m_state = 0;
      endcase
      for (int i = 0; i < N; i++) begin
        if (st == 2 && i == m_tgt) m_pend[i] = 1'b0;
        if (irq_req[i] && !m_irq_q[i]) m_pend[i] = 1'b1;
      end
      m_irq_q = irq_req;
      if (cfg_we) begin
        m_en[cfg_line] = cfg_en;
        m_prio[cfg_line] = int'(cfg_prio);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev;
      ev = (m_state == 1 || m_state == 3 || m_state == 4);
      if (mem_valid && mem_ready && mem_op == 2'd0) dut_saves++;
      chk("R1 pending", 64'(pending), 64'(m_pend));
      chk("R6 mem_valid", 64'(mem_valid), 64'(ev));
      if (ev) begin
        chk("R6 mem_op", 64'(mem_op), (m_state == 3) ? 64'd2 : (m_state == 4) ? 64'd1 : 64'd0);
        chk("R5 mem_addr", 64'(mem_addr),
            (m_state == 3) ? 64'(VBASE + 32'(m_tgt) * 4) : 64'(m_cnt));
      end
      chk("R3 accept_strobe", 64'(accept_strobe), 64'(m_state == 2));
      if (m_state == 2) chk("R3 accept_id", 64'(accept_id), 64'(m_tgt));
      chk("R5 handler_start", 64'(handler_start), 64'(m_hs));
      if (m_hs) chk("R5 handler_pc", 64'(handler_pc), 64'(m_pc));
      chk("R7 resume", 64'(resume), 64'(m_res));
      chk("R11 nest_depth", 64'(nest_depth), 64'(stk_id.size()));
      if (stk_id.size() > 0) chk("R11 active_id", 64'(active_id), 64'(stk_id[stk_id.size()-1]));
      chk("R8 R9 entry_kind", 64'(entry_kind), 64'(m_ekind));
    end
  end

  // memory ready, changed just after the edge
  initial begin
    logic [7:0] lf = 8'hA7;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (rdy_mode)
        0:       mem_ready = 1'b1;
        1:       mem_ready = lf[0];
        default: mem_ready = lf[0] & lf[2];
      endcase
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_w(input int l, input bit e, input int p);
    cfg_we = 1'b1; cfg_line = 3'(l); cfg_en = e; cfg_prio = 3'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic settle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      q = (m_state == 0) ? q + 1 : 0;
    end
  endtask

  task automatic finish_h();
    settle();
    handler_done = 1'b1;
    @(negedge clk);
    handler_done = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pending", 64'(pending), 64'd0);
    chk("R1 reset depth", 64'(nest_depth), 64'd0);
    chk("R1 reset mem idle", 64'(mem_valid), 64'd0);

    cfg_w(0, 1, 5); cfg_w(1, 1, 5); cfg_w(2, 1, 2); cfg_w(3, 1, 7);
    cfg_w(4, 1, 0); cfg_w(5, 1, 3); cfg_w(6, 1, 5); cfg_w(7, 0, 1);

    // R5 fresh entry and R7 exit
    pulse(8'h08); settle();
    chk("R5 depth", 64'(nest_depth), 64'd1);
    chk("R5 active", 64'(active_id), 64'd3);
    chk("R5 kind", 64'(entry_kind), 64'd0);
    finish_h();
    chk("R7 depth back", 64'(nest_depth), 64'd0);

    // R3 tie, then R8 chain
    pulse(8'h03); settle();
    chk("R3 tie winner", 64'(active_id), 64'd0);
    chk("R3 loser pending", 64'(pending[1]), 64'd1);
    finish_h();
    chk("R8 chained id", 64'(active_id), 64'd1);
    chk("R8 chained kind", 64'(entry_kind), 64'd1);
    chk("R8 depth kept", 64'(nest_depth), 64'd1);
    finish_h();

    // R4 equal waits, higher nests
    rdy_mode = 1;
    pulse(8'h01); settle();
    pulse(8'h40); tick(20);
    chk("R4 equal waits", 64'(nest_depth), 64'd1);
    chk("R4 equal pending", 64'(pending[6]), 64'd1);
    pulse(8'h04); settle();
    chk("R11 nested depth", 64'(nest_depth), 64'd2);
    chk("R11 nested active", 64'(active_id), 64'd2);
    finish_h();
    chk("R7 back to preempted", 64'(active_id), 64'd0);
    chk("R7 depth", 64'(nest_depth), 64'd1);
    finish_h();
    chk("R8 chain from thread", 64'(active_id), 64'd6);
    chk("R8 kind", 64'(entry_kind), 64'd1);
    finish_h();

    // R9 late arrival
    rdy_mode = 2;
    pulse(8'h08);
    while (m_state != 1) @(negedge clk);
    dut_saves = 0;
    tick(2);
    pulse(8'h10); settle();
    chk("R9 late target", 64'(active_id), 64'd4);
    chk("R9 late kind", 64'(entry_kind), 64'd2);
    chk("R9 low still pending", 64'(pending[3]), 64'd1);
    chk("R9 one stacking", 64'(dut_saves), 64'(CTXW));
    finish_h();
    chk("R8 chain after late", 64'(active_id), 64'd3);
    finish_h();

    // R2 disabled line
    rdy_mode = 1;
    pulse(8'h80); tick(30);
    chk("R2 pends while off", 64'(pending[7]), 64'd1);
    chk("R2 not accepted", 64'(nest_depth), 64'd0);
    chk("R2 memory idle", 64'(mem_valid), 64'd0);
    cfg_w(7, 1, 4); settle();
    chk("R2 accepted once on", 64'(active_id), 64'd7);
    finish_h();

    // R10 re-pend while running
    pulse(8'h20); settle();
    chk("R1 cleared on accept", 64'(pending[5]), 64'd0);
    pulse(8'h20); tick(2);
    chk("R10 re-pended", 64'(pending[5]), 64'd1);
    chk("R10 depth", 64'(nest_depth), 64'd1);
    finish_h();
    chk("R10 rerun", 64'(active_id), 64'd5);
    finish_h();

    // random phase, distinct levels for deep nesting
    for (int i = 0; i < N; i++) cfg_w(i, 1, 7 - i);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      irq_req = ($urandom % 6 == 0) ? N'(1) << ($urandom % N) : '0;
      handler_done = (m_state == 0 && stk_id.size() > 0 && $urandom % 10 == 0);
    end
    @(negedge clk);
    irq_req = '0; handler_done = 1'b0;
    settle();
    while (stk_id.size() > 0) finish_h();
    chk("R11 drained", 64'(nest_depth), 64'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule